// File: doc/BRIEF.md
# Interrupt-Level Banked Register File

This block holds the general registers of a small 16-bit processor: four banks of sixteen 16-bit registers, one bank for each interrupt level. Entry 0 of each bank is that level's program counter. Entry 1 is, by software convention, its link register. Instruction execution sees only the bank of the current level, through two read ports and one write port. Because every level owns a full bank, a level switch saves and restores nothing. A handler simply starts using its own bank.

A built-in arbiter latches requests for levels 1 to 3. It moves the active level only on an instruction-boundary strobe, and it always picks the highest pending level. When no level is pending it falls back to level 0. A handler leaves its level by pulsing the exit input, which drops that level's pending request.

The whole file is also visible to the storage bus through a byte-wide port. This port covers a 128-byte window at the bottom of the address space, so software can inspect or preset any register of any level.

Top module: `lvl_bank_regs`

## Requirements
- R1: While reset is high and on the edge that releases it, the active level is 0, no request is pending, and the program counter (entry 0) of every bank reads 0.
- R2: Instruction read ports A and B return, one clock after the index is presented, the register of that index in the bank of the current active level.
- R3: The instruction write port writes the full 16-bit word into the bank of the current active level, at the clock edge where the write enable is high.
- R4: Byte address decoding on the bus port: bits 6..5 select the level, bits 4..1 select the register, and bit 0 selects the byte, where 0 is the high byte and 1 is the low byte. For example, address 0x55 is the low byte of register 10 of level 2.
- R5: A bus write changes only the addressed byte. A bus read returns the addressed byte one clock after the request.
- R6: If an instruction write and a bus write hit the same register in the same cycle, only the instruction write takes effect. If they hit different registers, both take effect.
- R7: A request on lvl_req_i bit k (k = 1..3) stays pending after its pulse. The active level changes only in a cycle where boundary_i is high.
- R8: At a boundary the active level becomes the highest pending level, or 0 when nothing is pending. Bit 0 of lvl_req_i has no effect.
- R9: An exit pulse clears the pending request of the current active level. A request for that same level in the same cycle keeps it pending.
- R10: A boundary in the same cycle as a request or an exit decides using the pending set after that request or exit.
- R11: Writes through either port to one bank leave the registers of all other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_req_i | input | 4 | Level request pulses, one bit per level (bit 0 unused) |
| boundary_i | input | 1 | Instruction-boundary strobe |
| lvl_exit_i | input | 1 | Current handler finished; drop its request |
| active_lvl_o | output | 2 | Current interrupt level |
| rda_idx_i | input | 4 | Read port A register index |
| rda_data_o | output | 16 | Read port A data, one clock later |
| rdb_idx_i | input | 4 | Read port B register index |
| rdb_data_o | output | 16 | Read port B data, one clock later |
| wr_en_i | input | 1 | Instruction write enable |
| wr_idx_i | input | 4 | Instruction write register index |
| wr_data_i | input | 16 | Instruction write data |
| mm_en_i | input | 1 | Bus access strobe |
| mm_we_i | input | 1 | Bus access is a write |
| mm_addr_i | input | 7 | Bus byte address inside the register window |
| mm_wdata_i | input | 8 | Bus write byte |
| mm_rdata_o | output | 8 | Bus read byte, one clock after the request |

## Verification
The assertions watch the arbiter on every cycle:
- the level holds between boundaries;
- after a boundary the chosen level is pending and no higher level is;
- a request always leaves its bit set;
- an exit clears the bit of the level it left;
- reset returns the level and pending set to zero.

Some behaviour only the bench scenarios can show. These are the contents of the storage: the byte-address map, byte-lane isolation, bank independence, the winner of a same-register collision, and program counters that read zero after reset. The bench checks these by filling and sweeping all 64 registers through both ports and comparing against values it computes itself.

// File: rtl/lvl_regs_pkg.sv
package lvl_regs_pkg;

  // Byte lane selected by bit 0 of a bus address.
  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;

endpackage

// File: rtl/lvl_arbiter.sv
module lvl_arbiter #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  boundary_i,
  input  logic                  exit_i,
  output logic [LVL_W-1:0]      lvl_o,
  output logic [NUM_LEVELS-1:0] pend_o
);

  logic [NUM_LEVELS-1:0] pend_q;
  logic [NUM_LEVELS-1:0] pend_nxt;
  logic [NUM_LEVELS-1:0] clr;
  logic [LVL_W-1:0]      lvl_q;
  logic [LVL_W-1:0]      top_lvl;

  always_comb begin
    clr = '0;
    if (exit_i) clr[lvl_q] = 1'b1;
    // A new request beats a simultaneous exit; level 0 never pends.
    pend_nxt    = (pend_q & ~clr) | req_i;
    pend_nxt[0] = 1'b0;
    top_lvl = '0;
    for (int i = 1; i < NUM_LEVELS; i++) begin
      if (pend_nxt[i]) top_lvl = LVL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      lvl_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (boundary_i) lvl_q <= top_lvl;
    end
  end

  assign lvl_o  = lvl_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/bank_store.sv
module bank_store
  import lvl_regs_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 16,
  localparam int DEPTH     = NUM_LEVELS * NUM_REGS,
  localparam int FLAT_W    = $clog2(DEPTH),
  localparam int BYTE_W    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAT_W-1:0] ra_idx_i,
  input  logic [FLAT_W-1:0] rb_idx_i,
  input  logic [FLAT_W-1:0] rm_idx_i,
  output logic [DATA_W-1:0] ra_q_o,
  output logic [DATA_W-1:0] rb_q_o,
  output logic [DATA_W-1:0] rm_q_o,
  input  logic              wi_en_i,
  input  logic [FLAT_W-1:0] wi_idx_i,
  input  logic [DATA_W-1:0] wi_data_i,
  input  logic              wb_en_i,
  input  logic [FLAT_W-1:0] wb_idx_i,
  input  lane_e             wb_lane_i,
  input  logic [BYTE_W-1:0] wb_data_i
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              byte_ok;

  // The word write owns the register outright when both ports collide.
  assign byte_ok = wb_en_i && !(wi_en_i && (wi_idx_i == wb_idx_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_LEVELS; l++) begin
        mem[l*NUM_REGS] <= '0;
      end
    end else begin
      if (byte_ok) begin
        if (wb_lane_i == LANE_LO) mem[wb_idx_i][BYTE_W-1:0] <= wb_data_i;
        else                      mem[wb_idx_i][DATA_W-1:BYTE_W] <= wb_data_i;
      end
      if (wi_en_i) mem[wi_idx_i] <= wi_data_i;
    end
  end

  always_ff @(posedge clk) begin
    ra_q_o <= mem[ra_idx_i];
    rb_q_o <= mem[rb_idx_i];
    rm_q_o <= mem[rm_idx_i];
  end

endmodule

// File: rtl/lvl_bank_regs.sv
module lvl_bank_regs
  import lvl_regs_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 16,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int RIDX_W    = $clog2(NUM_REGS),
  localparam int FLAT_W    = LVL_W + RIDX_W,
  localparam int MM_AW     = FLAT_W + 1,
  localparam int BYTE_W    = DATA_W / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] lvl_req_i,
  input  logic                  boundary_i,
  input  logic                  lvl_exit_i,
  output logic [LVL_W-1:0]      active_lvl_o,
  input  logic [RIDX_W-1:0]     rda_idx_i,
  output logic [DATA_W-1:0]     rda_data_o,
  input  logic [RIDX_W-1:0]     rdb_idx_i,
  output logic [DATA_W-1:0]     rdb_data_o,
  input  logic                  wr_en_i,
  input  logic [RIDX_W-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  mm_en_i,
  input  logic                  mm_we_i,
  input  logic [MM_AW-1:0]      mm_addr_i,
  input  logic [BYTE_W-1:0]     mm_wdata_i,
  output logic [BYTE_W-1:0]     mm_rdata_o
);

  logic [LVL_W-1:0]      lvl_w;
  logic [NUM_LEVELS-1:0] pend_w;
  logic [DATA_W-1:0]     rm_word;
  lane_e                 mm_lane;
  lane_e                 lane_q;

  lvl_arbiter #(.NUM_LEVELS(NUM_LEVELS)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .req_i      (lvl_req_i),
    .boundary_i (boundary_i),
    .exit_i     (lvl_exit_i),
    .lvl_o      (lvl_w),
    .pend_o     (pend_w)
  );

  assign mm_lane = lane_e'(mm_addr_i[0]);

  bank_store #(
    .NUM_LEVELS (NUM_LEVELS),
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .ra_idx_i  ({lvl_w, rda_idx_i}),
    .rb_idx_i  ({lvl_w, rdb_idx_i}),
    .rm_idx_i  (mm_addr_i[MM_AW-1:1]),
    .ra_q_o    (rda_data_o),
    .rb_q_o    (rdb_data_o),
    .rm_q_o    (rm_word),
    .wi_en_i   (wr_en_i),
    .wi_idx_i  ({lvl_w, wr_idx_i}),
    .wi_data_i (wr_data_i),
    .wb_en_i   (mm_en_i && mm_we_i),
    .wb_idx_i  (mm_addr_i[MM_AW-1:1]),
    .wb_lane_i (mm_lane),
    .wb_data_i (mm_wdata_i)
  );

  always_ff @(posedge clk) begin
    if (rst)          lane_q <= LANE_HI;
    else if (mm_en_i) lane_q <= mm_lane;
  end

  assign mm_rdata_o   = (lane_q == LANE_LO) ? rm_word[BYTE_W-1:0]
                                            : rm_word[DATA_W-1:BYTE_W];
  assign active_lvl_o = lvl_w;

endmodule

// File: rtl/lvl_bank_regs_chk.sv
module lvl_bank_regs_chk #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LEVELS-1:0] lvl_req_i,
  input logic                  boundary_i,
  input logic                  lvl_exit_i,
  input logic [LVL_W-1:0]      active_lvl_o,
  input logic [NUM_LEVELS-1:0] pend_w
);

  // R1: reset leaves level 0 with nothing pending
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (active_lvl_o == '0) && (pend_w == '0));

  // R7: the level only moves on a boundary strobe
  p_hold_level_r7: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> $stable(active_lvl_o));

  // R8: after a boundary the level is pending (or 0) and nothing above it pends
  p_pick_highest_r8: assert property (@(posedge clk) disable iff (rst)
    boundary_i |=> ((active_lvl_o == '0) || pend_w[active_lvl_o]) &&
                   (32'(pend_w) < (32'd1 << (32'(active_lvl_o) + 1))));

  // R9: exit drops the request of the level being left
  p_exit_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (lvl_exit_i && (active_lvl_o != '0) && !lvl_req_i[active_lvl_o])
      |=> !pend_w[$past(active_lvl_o)]);

  for (genvar k = 1; k < NUM_LEVELS; k++) begin : g_req
    // R7: a request pulse is latched
    p_req_latched_r7: assert property (@(posedge clk) disable iff (rst)
      lvl_req_i[k] |=> pend_w[k]);
  end

endmodule

bind lvl_bank_regs lvl_bank_regs_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lvl_req_i    (lvl_req_i),
  .boundary_i   (boundary_i),
  .lvl_exit_i   (lvl_exit_i),
  .active_lvl_o (active_lvl_o),
  .pend_w       (pend_w)
);

// File: tb/lvl_bank_regs_tb_top.sv
`timescale 1ns/1ps
module lvl_bank_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  lvl_req_i = '0;
  logic        boundary_i = 1'b0;
  logic        lvl_exit_i = 1'b0;
  logic [1:0]  active_lvl_o;
  logic [3:0]  rda_idx_i = '0;
  logic [15:0] rda_data_o;
  logic [3:0]  rdb_idx_i = '0;
  logic [15:0] rdb_data_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        mm_en_i = 1'b0;
  logic        mm_we_i = 1'b0;
  logic [6:0]  mm_addr_i = '0;
  logic [7:0]  mm_wdata_i = '0;
  logic [7:0]  mm_rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model [64];

  always #2.5 clk = ~clk;

  lvl_bank_regs dut_i (.*);

  function automatic logic [15:0] pat(int l, int r, int s);
    return 16'((l * 4099 + r * 577 + s * 8191 + 13) * 41) ^ (s[0] ? 16'hC3A5 : 16'h5A3C);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mm_wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk); mm_en_i = 1; mm_we_i = 1; mm_addr_i = a; mm_wdata_i = d;
    @(negedge clk); mm_en_i = 0; mm_we_i = 0;
  endtask

  task automatic mm_rd(logic [6:0] a, output logic [7:0] d);
    @(negedge clk); mm_en_i = 1; mm_we_i = 0; mm_addr_i = a;
    @(posedge clk); #1; d = mm_rdata_o;
    @(negedge clk); mm_en_i = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [3:0] b, output logic [15:0] da, output logic [15:0] db);
    @(negedge clk); rda_idx_i = a; rdb_idx_i = b;
    @(posedge clk); #1; da = rda_data_o; db = rdb_data_o;
  endtask

  task automatic wr(logic [3:0] i, logic [15:0] d);
    @(negedge clk); wr_en_i = 1; wr_idx_i = i; wr_data_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic ctl(logic [3:0] req, logic bnd, logic ex);
    @(negedge clk); lvl_req_i = req; boundary_i = bnd; lvl_exit_i = ex;
    @(negedge clk); lvl_req_i = '0; boundary_i = 0; lvl_exit_i = 0;
  endtask

  task automatic sweep_mm(string tag);
    logic [7:0] b;
    for (int a = 0; a < 128; a++) begin
      mm_rd(7'(a), b);
      chk(tag, b, a[0] ? model[a/2][7:0] : model[a/2][15:8]);
    end
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] da, db;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 level after reset", active_lvl_o, 0);
    for (int l = 0; l < 4; l++) begin
      mm_rd(7'(l * 32), b);     chk("R1 pc high byte zero", b, 0);
      mm_rd(7'(l * 32 + 1), b); chk("R1 pc low byte zero", b, 0);
    end
    ctl(4'b0000, 1, 0);
    chk("R1 nothing pending after reset", active_lvl_o, 0);

    // Fill every register through the bus port, high byte then low byte.
    for (int e = 0; e < 64; e++) begin
      model[e] = pat(e / 16, e % 16, 0);
      mm_wr(7'(e * 2), model[e][15:8]);
      mm_wr(7'(e * 2 + 1), model[e][7:0]);
    end
    sweep_mm("R4 bus map readback");
    mm_rd(7'h55, b);
    chk("R4 addr 0x55 is low byte of level2 reg10", b, pat(2, 10, 0) & 16'h00FF);

    // R5: a single byte write leaves its partner byte alone.
    mm_wr(7'h4B, 8'h9E);
    model[37][7:0] = 8'h9E;
    mm_rd(7'h4A, b); chk("R5 high byte kept", b, model[37][15:8]);
    mm_rd(7'h4B, b); chk("R5 low byte written", b, 8'h9E);

    // Visit each level, read and rewrite its bank through the instruction ports.
    for (int l = 0; l < 4; l++) begin
      if (l != 0) begin
        ctl(4'(1 << l), 0, 0);
        chk("R7 no switch without boundary", active_lvl_o, 0);
        ctl(4'b0000, 1, 0);
        chk("R8 switch to requested level", active_lvl_o, l);
      end
      for (int r = 0; r < 16; r++) begin
        rd(4'(r), 4'(15 - r), da, db);
        chk("R2 port A bank read", da, model[l * 16 + r]);
        chk("R2 port B bank read", db, model[l * 16 + 15 - r]);
      end
      for (int r = 0; r < 16; r++) begin
        model[l * 16 + r] = pat(l, r, 1);
        wr(4'(r), model[l * 16 + r]);
      end
      rd(4'd7, 4'd0, da, db);
      chk("R3 written word read back", da, model[l * 16 + 7]);
      if (l != 0) begin
        ctl(4'b0000, 0, 1);
        chk("R7 exit alone keeps level", active_lvl_o, l);
        ctl(4'b0000, 1, 0);
        chk("R9 return to level 0 after exit", active_lvl_o, 0);
      end
    end
    sweep_mm("R11 R3 banks after per-level writes");

    // Priority and arbitration corner cases.
    ctl(4'b1010, 1, 0);
    chk("R8 R10 highest of level1 and level3", active_lvl_o, 3);
    ctl(4'b0000, 1, 1);
    chk("R10 exit and boundary together fall to level1", active_lvl_o, 1);
    ctl(4'b0100, 0, 0);
    chk("R7 level2 request waits for boundary", active_lvl_o, 1);
    ctl(4'b0000, 1, 0);
    chk("R8 preempt to level2", active_lvl_o, 2);
    ctl(4'b0000, 0, 1);
    ctl(4'b0000, 1, 0);
    chk("R9 back to pending level1", active_lvl_o, 1);
    ctl(4'b0010, 0, 1);
    ctl(4'b0000, 1, 0);
    chk("R9 same-cycle request keeps level1 pending", active_lvl_o, 1);
    ctl(4'b0000, 1, 1);
    chk("R9 R10 exit empties pending set", active_lvl_o, 0);
    ctl(4'b0001, 1, 0);
    chk("R8 bit0 request has no effect", active_lvl_o, 0);
    ctl(4'b0000, 1, 0);
    chk("R8 idle boundary stays at 0", active_lvl_o, 0);

    // R6: collisions at level 0.
    @(negedge clk);
    wr_en_i = 1; wr_idx_i = 4'd5; wr_data_i = 16'h1234;
    mm_en_i = 1; mm_we_i = 1; mm_addr_i = 7'h0B; mm_wdata_i = 8'hEE;
    @(negedge clk);
    wr_en_i = 0; mm_en_i = 0; mm_we_i = 0;
    model[5] = 16'h1234;
    rd(4'd5, 4'd5, da, db);
    chk("R6 same register: word write wins", da, 16'h1234);
    @(negedge clk);
    wr_en_i = 1; wr_idx_i = 4'd6; wr_data_i = 16'hBEEF;
    mm_en_i = 1; mm_we_i = 1; mm_addr_i = 7'h2D; mm_wdata_i = 8'h77;
    @(negedge clk);
    wr_en_i = 0; mm_en_i = 0; mm_we_i = 0;
    model[6] = 16'hBEEF;
    model[22][7:0] = 8'h77;
    rd(4'd6, 4'd6, da, db);
    chk("R6 different registers: word write lands", da, 16'hBEEF);
    mm_rd(7'h2D, b);
    chk("R6 different registers: byte write lands", b, 8'h77);
    sweep_mm("R11 R6 final image");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule